// File: doc/BRIEF.md
# Waveform Timer Channel

One channel of a general-purpose timer. The channel always runs as a waveform generator. A counter of `CNT_W` bits (16 by default) advances once per qualified tick. The tick is an edge of one of eight sampled clock sources, taken on the rising or the falling edge, and it can be gated by the level of one of three external lines. The counter counts up or counts up and down. It can treat the third compare value (C) as its period. It can also stop, or switch its clock off, when it reaches C.

Two outputs, A and B, are built from events. Output A responds to a match with compare value A, a match with C, an external event and a software trigger. Output B uses compare value B in place of A. Each pairing of event and output has its own two-bit action code. One 32-bit mode word holds every setting. That word is locked while the write-protect input is high. The compare values are written through the same narrow write port.

Top module: `wtc_channel`

## Requirements
- R1: After reset the mode word and all three compare values are zero. The count is 0, outputs A and B are low, `wave_b_oe` is low, the clock is off and the counter is idle.
- R2: A write to address 0 loads the mode word only while `wp_en` is low. With `wp_en` high the write leaves the mode word and all outputs unchanged. Addresses 1, 2 and 3 load compare values A, B and C from the low `CNT_W` bits and are never locked.
- R3: Mode bits [18:16] pick the tick source: values 0 to 4 select `int_clk[0..4]` and values 5 to 7 select `xc[0..2]`. Each source is sampled on `clk`. A tick is a rising edge of the selected source, or a falling edge when bit 19 is set.
- R4: Mode bits [21:20] gate the tick. Value 0 passes every tick, and value k (1 to 3) passes a tick only while `xc[k-1]` is high.
- R5: Mode bits [23:22] choose the counting law. 0: count up and wrap from all ones to 0. 1: count up and down, turning at all ones and at 0. 2: count up and return to 0 on the tick after reaching C. 3: count up and down, turning at C and at 0.
- R6: A compare match fires when a counter step lands on the compare value. The matching output changes at the same clock edge as the count.
- R7: With bit 29 set, a C match stops the counter at C until the next trigger. With bit 30 set, a C match switches the clock off until the next enable command.
- R8: A software trigger resets the count to 0 in the up direction and starts the counter. When bit 28 is set, a detected external event does the same.
- R9: Mode bits [25:24] select the external event edge: 0 none, 1 rising, 2 falling, 3 both. Bits [27:26] select its source: 0 `tio_b_in`, k = `xc[k-1]`. The event drives the output actions whatever the value of bit 28.
- R10: The action codes are 0 none, 1 set, 2 clear and 3 toggle. Output A takes its codes from the A-match field [1:0], the C-match field [3:2], the external field [5:4] and the software field [7:6]. Output B takes its codes from the B-match field [9:8], the C-match field [11:10], the external field [13:12] and the software field [15:14].
- R11: Several events can reach one output in the same cycle. In that case only the code of the highest-ranked event whose code is not 0 is applied. The order is software trigger, then external event, then C match, then the A or B match.
- R12: While bits [27:26] are 0, `wave_b_oe` is low and output B holds its value. Otherwise `wave_b_oe` is high.
- R13: The counter steps only while the clock is on and the counter is started. `cmd_en` turns the clock on and `cmd_dis` turns it off. `cmd_dis` wins when both are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode word, 1 compare A, 2 compare B, 3 compare C |
| wr_data | input | 32 | Write data |
| wp_en | input | 1 | Locks the mode word while high |
| int_clk | input | 5 | Internal clock sources, sampled |
| xc | input | 3 | External clock, gate and event lines |
| tio_b_in | input | 1 | Line B used as an event input |
| sw_trig | input | 1 | Software trigger pulse |
| cmd_en | input | 1 | Clock enable command |
| cmd_dis | input | 1 | Clock disable command |
| cnt_o | output | CNT_W | Current count |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| wave_b_oe | output | 1 | Drive enable for line B |

## Verification
The bench targets the turning points of each counting law. These are the wrap at all ones, the turn at C and at 0 in up-down modes, and the return to 0 after C. A design that is off by one there shows a count that is one step early or late, or a direction that never reverses. Simultaneous software and external events on one output check the ranking: a swapped order leaves output A cleared where it should be set. The stop and disable paths are run back to back. A design that treats them alike restarts on a trigger when it should wait for an enable, or the other way round. A locked mode write and line B used as an input are also exercised. Leaking either one makes `wave_b_oe` rise, or output B move, with no cause.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
// Shared types for the waveform timer channel.
// Assumes: the mode word layout below is the one software writes at address 0.
package wtc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    // Mode word, most significant field first.
    typedef struct packed {
        logic       rsvd;      // [31]
        logic       dis_rc;    // [30] switch clock off on C match
        logic       stop_rc;   // [29] stop counter on C match
        logic       trig_en;   // [28] external event restarts counter
        logic [1:0] ev_src;    // [27:26]
        logic [1:0] ev_edge;   // [25:24] bit0 rising, bit1 falling
        logic [1:0] wsel;      // [23:22] bit0 up-down, bit1 C is period
        logic [1:0] gate;      // [21:20]
        logic       inv;       // [19]
        logic [2:0] clk_src;   // [18:16]
        act_e       b_sw;      // [15:14]
        act_e       b_ext;     // [13:12]
        act_e       b_rc;      // [11:10]
        act_e       b_rb;      // [9:8]
        act_e       a_sw;      // [7:6]
        act_e       a_ext;     // [5:4]
        act_e       a_rc;      // [3:2]
        act_e       a_ra;      // [1:0]
    } mode_t;

endpackage

// File: rtl/wtc_edge_pick.sv
`timescale 1ns/1ps
// Selects one of N sampled lines and emits a one-cycle pulse on its rising
// and/or falling edge. Assumes the lines are already synchronous to clk.
module wtc_edge_pick #(
    parameter int N  = 8,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  sig,
    input  logic [SW-1:0] sel,
    input  logic          on_rise,
    input  logic          on_fall,
    output logic          pulse
);
    logic cur;
    logic prev_q;

    assign cur = sig[sel];

    // Remember the selected line's last sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign pulse = (on_rise & cur & ~prev_q) | (on_fall & ~cur & prev_q);

endmodule

// File: rtl/wtc_counter.sv
`timescale 1ns/1ps
// Counter core: counting laws, restart, stop and clock on/off, compare
// matches. Assumes tick and trig are single-cycle pulses on clk.
module wtc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic [1:0]       wsel,
    input  logic             stop_rc,
    input  logic             dis_rc,
    input  logic [CNT_W-1:0] ra,
    input  logic [CNT_W-1:0] rb,
    input  logic [CNT_W-1:0] rc,
    output logic [CNT_W-1:0] cnt,
    output logic             m_ra,
    output logic             m_rb,
    output logic             m_rc
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic             en_q, run_q, up_q;
    logic [CNT_W-1:0] cnt_q, nxt, lim;
    logic             nxt_up, adv;

    assign adv = en_q & run_q & tick & ~trig;
    assign lim = wsel[1] ? rc : TOP;

    // Next count and direction under the selected counting law.
    always_comb begin
        nxt_up = up_q;
        nxt    = cnt_q + 1'b1;
        if (!wsel[0]) begin
            nxt_up = 1'b1;
            if (wsel[1] && cnt_q == rc) nxt = '0;
        end else if (up_q) begin
            if (cnt_q == lim) begin
                nxt_up = 1'b0;
                nxt    = cnt_q - 1'b1;
            end
        end else if (cnt_q == '0) begin
            nxt_up = 1'b1;
        end else begin
            nxt = cnt_q - 1'b1;
        end
    end

    assign m_ra = adv & (nxt == ra);
    assign m_rb = adv & (nxt == rb);
    assign m_rc = adv & (nxt == rc);

    // Count register with restart taking precedence over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (trig) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (adv) begin
            cnt_q <= nxt;
            up_q  <= nxt_up;
        end
    end

    // Clock on/off state: disable command first, then enable, then C match.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (cmd_dis)          en_q <= 1'b0;
        else if (cmd_en)           en_q <= 1'b1;
        else if (dis_rc && m_rc)   en_q <= 1'b0;
    end

    // Started/stopped state: trigger starts, C match stops when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_q <= 1'b0;
        else if (trig)             run_q <= 1'b1;
        else if (stop_rc && m_rc)  run_q <= 1'b0;
    end

    assign cnt = cnt_q;

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en_q && run_q) && !trig) |=> $stable(cnt_q));
    p_trig_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt_q == '0));
    p_stop_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_rc && m_rc) |=> !run_q);
    p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)
                 || (cnt_q == '0)));

endmodule

// File: rtl/wtc_wave_out.sv
`timescale 1ns/1ps
// One waveform output: applies the action of the highest-ranked active event.
// ev/acts order: [3] software, [2] external, [1] C match, [0] A/B match.
module wtc_wave_out
    import wtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [3:0] ev,
    input  logic [7:0] acts,
    output logic       q
);
    act_e sel;
    logic q_r;

    // Pick the action; higher index overrides lower.
    always_comb begin
        sel = ACT_NONE;
        for (int i = 0; i < 4; i++) begin
            if (ev[i] && act_e'(acts[2*i +: 2]) != ACT_NONE) sel = act_e'(acts[2*i +: 2]);
        end
    end

    // Output level register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else if (!hold) begin
            case (sel)
                ACT_SET: q_r <= 1'b1;
                ACT_CLR: q_r <= 1'b0;
                ACT_TGL: q_r <= ~q_r;
                default: q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == 4'b0000) |=> $stable(q_r));

endmodule

// File: rtl/wtc_channel.sv
`timescale 1ns/1ps
// Waveform timer channel top: register port, tick and event selection,
// counter core and the two waveform outputs.
// Assumes all inputs are synchronous to clk.
module wtc_channel
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             wp_en,
    input  logic [4:0]       int_clk,
    input  logic [2:0]       xc,
    input  logic             tio_b_in,
    input  logic             sw_trig,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wave_a,
    output logic             wave_b,
    output logic             wave_b_oe
);
    localparam int NOUT = 2;

    mode_t            mode_q;
    logic [CNT_W-1:0] ra_q, rb_q, rc_q;
    logic             raw_tick, tick, ev_pulse, trig;
    logic             m_ra, m_rb, m_rc;
    logic [3:0]       gate_v;
    logic [3:0]       ev_v   [NOUT];
    logic [7:0]       act_v  [NOUT];
    logic             hold_v [NOUT];
    logic             q_v    [NOUT];
    logic             unused_bits;

    assign unused_bits = ^{wr_data[31:CNT_W], mode_q.rsvd};

    // Register write port; only the mode word honours write protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            rc_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0:    if (!wp_en) mode_q <= mode_t'(wr_data);
                2'd1:    ra_q <= wr_data[CNT_W-1:0];
                2'd2:    rb_q <= wr_data[CNT_W-1:0];
                default: rc_q <= wr_data[CNT_W-1:0];
            endcase
        end
    end

    wtc_edge_pick #(.N(8)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     ({xc, int_clk}),
        .sel     (mode_q.clk_src),
        .on_rise (~mode_q.inv),
        .on_fall (mode_q.inv),
        .pulse   (raw_tick)
    );

    assign gate_v = {xc, 1'b1};
    assign tick   = raw_tick & gate_v[mode_q.gate];

    wtc_edge_pick #(.N(4)) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     ({xc, tio_b_in}),
        .sel     (mode_q.ev_src),
        .on_rise (mode_q.ev_edge[0]),
        .on_fall (mode_q.ev_edge[1]),
        .pulse   (ev_pulse)
    );

    assign trig = sw_trig | (mode_q.trig_en & ev_pulse);

    wtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .trig    (trig),
        .cmd_en  (cmd_en),
        .cmd_dis (cmd_dis),
        .wsel    (mode_q.wsel),
        .stop_rc (mode_q.stop_rc),
        .dis_rc  (mode_q.dis_rc),
        .ra      (ra_q),
        .rb      (rb_q),
        .rc      (rc_q),
        .cnt     (cnt_o),
        .m_ra    (m_ra),
        .m_rb    (m_rb),
        .m_rc    (m_rc)
    );

    assign ev_v[0]   = {sw_trig, ev_pulse, m_rc, m_ra};
    assign act_v[0]  = {mode_q.a_sw, mode_q.a_ext, mode_q.a_rc, mode_q.a_ra};
    assign hold_v[0] = 1'b0;
    assign ev_v[1]   = {sw_trig, ev_pulse, m_rc, m_rb};
    assign act_v[1]  = {mode_q.b_sw, mode_q.b_ext, mode_q.b_rc, mode_q.b_rb};
    assign hold_v[1] = (mode_q.ev_src == 2'd0);

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        wtc_wave_out u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (hold_v[g]),
            .ev    (ev_v[g]),
            .acts  (act_v[g]),
            .q     (q_v[g])
        );
    end

    assign wave_a    = q_v[0];
    assign wave_b    = q_v[1];
    assign wave_b_oe = (mode_q.ev_src != 2'd0);

    p_wp_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wp_en) |=> $stable(mode_q));
    p_b_input_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.ev_src == 2'd0) |=> $stable(wave_b));

endmodule

// File: tb/wtc_channel_tb_top.sv
`timescale 1ns/1ps
// Lock-step bench: a behavioural model of the requirements runs beside the
// design and every output is compared each cycle, plus named corner checks.
module wtc_channel_tb_top;
    localparam int  TW       = 10;
    localparam real CLK_HALF = 10.0;
    localparam logic [31:0] BASE_ACT = 32'h0000_B76D;
    localparam logic [31:0] SRC_XC0  = 32'h0400_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          wp_en = 1'b0;
    logic [4:0]    ick = '0;
    logic [2:0]    xc = '0;
    logic          tio = 1'b0;
    logic          sw_trig = 1'b0;
    logic          cmd_en = 1'b0;
    logic          cmd_dis = 1'b0;
    logic [TW-1:0] cnt_o;
    logic          wave_a, wave_b, wave_b_oe;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    k_sw = 0, k_xc = 0, k_tio = 0, k_cmd = 0;

    // model state
    logic [31:0]   m_mode = '0;
    logic [TW-1:0] m_ra = '0, m_rb = '0, m_rc = '0, m_cnt = '0;
    logic          m_up = 1'b1, m_en = 1'b0, m_run = 1'b0;
    logic          m_a = 1'b0, m_b = 1'b0, m_pc = 1'b0, m_pe = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    wtc_channel #(.CNT_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp_en(wp_en), .int_clk(ick), .xc(xc),
        .tio_b_in(tio), .sw_trig(sw_trig), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
        .cnt_o(cnt_o), .wave_a(wave_a), .wave_b(wave_b), .wave_b_oe(wave_b_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Action rule of R10 with the ranking of R11: ev = {sw, ext, C, A/B}.
    function automatic logic apply_act(input logic q, input logic [3:0] ev,
                                       input logic [7:0] acts);
        logic [1:0] a;
        if      (ev[3] && acts[7:6] != 2'd0) a = acts[7:6];
        else if (ev[2] && acts[5:4] != 2'd0) a = acts[5:4];
        else if (ev[1] && acts[3:2] != 2'd0) a = acts[3:2];
        else if (ev[0] && acts[1:0] != 2'd0) a = acts[1:0];
        else                                 a = 2'd0;
        case (a)
            2'd1:    return 1'b1;
            2'd2:    return 1'b0;
            2'd3:    return ~q;
            default: return q;
        endcase
    endfunction

    task automatic model_step();
        logic [7:0]    csrc;
        logic [3:0]    esrc, gv;
        logic          cs, es, tk, evd, trg, adv, up_nx, mra, mrb, mrc, na, nb;
        logic [TW-1:0] nx, lim;
        logic [1:0]    ws;
        csrc = {xc, ick};
        cs   = csrc[m_mode[18:16]];
        tk   = m_mode[19] ? (m_pc & ~cs) : (cs & ~m_pc);
        gv   = {xc, 1'b1};
        tk   = tk & gv[m_mode[21:20]];
        esrc = {xc, tio};
        es   = esrc[m_mode[27:26]];
        evd  = (m_mode[24] & es & ~m_pe) | (m_mode[25] & ~es & m_pe);
        m_pc = cs;
        m_pe = es;
        trg  = sw_trig | (m_mode[28] & evd);
        adv  = m_en & m_run & tk & ~trg;
        ws   = m_mode[23:22];
        up_nx = 1'b1;
        nx    = m_cnt + 1'b1;
        if (ws == 2'd2) begin
            if (m_cnt == m_rc) nx = '0;
        end else if (ws[0]) begin
            lim = (ws == 2'd3) ? m_rc : {TW{1'b1}};
            if (m_up) begin
                if (m_cnt == lim) begin up_nx = 1'b0; nx = m_cnt - 1'b1; end
            end else if (m_cnt != '0) begin
                up_nx = 1'b0;
                nx = m_cnt - 1'b1;
            end
        end
        mra = adv && nx == m_ra;
        mrb = adv && nx == m_rb;
        mrc = adv && nx == m_rc;
        na = apply_act(m_a, {sw_trig, evd, mrc, mra}, m_mode[7:0]);
        nb = (m_mode[27:26] == 2'd0) ? m_b
             : apply_act(m_b, {sw_trig, evd, mrc, mrb}, m_mode[15:8]);
        m_a = na;
        m_b = nb;
        if (trg)      begin m_cnt = '0; m_up = 1'b1; end
        else if (adv) begin m_cnt = nx; m_up = up_nx; end
        if (cmd_dis)                m_en = 1'b0;
        else if (cmd_en)            m_en = 1'b1;
        else if (m_mode[30] && mrc) m_en = 1'b0;
        if (trg)                    m_run = 1'b1;
        else if (m_mode[29] && mrc) m_run = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                2'd0: if (!wp_en) m_mode = wr_data;
                2'd1: m_ra = wr_data[TW-1:0];
                2'd2: m_rb = wr_data[TW-1:0];
                default: m_rc = wr_data[TW-1:0];
            endcase
        end
    endtask

    // One cycle: model, clock edge, compare at the falling edge, clear pulses.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, "count",  32'(cnt_o),   32'(m_cnt));
        chk(cur_req, "wave_a", 32'(wave_a),  32'(m_a));
        chk(cur_req, "wave_b", 32'(wave_b),  32'(m_b));
        chk(cur_req, "b_oe",   32'(wave_b_oe), 32'(m_mode[27:26] != 2'd0));
        wr_en = 1'b0; sw_trig = 1'b0; cmd_en = 1'b0; cmd_dis = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            ick[0]   = ~ick[0];
            ick[4:1] = 4'($urandom);
            for (int j = 0; j < 3; j++)
                if ($urandom_range(99) < k_xc) xc[j] = ~xc[j];
            if ($urandom_range(99) < k_tio) tio = ~tio;
            sw_trig = ($urandom_range(99) < k_sw);
            cmd_en  = ($urandom_range(99) < k_cmd);
            cmd_dis = ($urandom_range(199) < k_cmd);
            step();
        end
    endtask

    task automatic knobs(input int s, input int x, input int t, input int c);
        k_sw = s; k_xc = x; k_tio = t; k_cmd = c;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] held;
        int unused_seed;
        unused_seed = $urandom(32'd5171);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        chk("R1", "count", 32'(cnt_o), 0);
        chk("R1", "wave_a", 32'(wave_a), 0);
        chk("R1", "wave_b", 32'(wave_b), 0);
        chk("R1", "b_oe", 32'(wave_b_oe), 0);
        knobs(0, 0, 0, 0);
        run(8);
        chk("R1", "idle count", 32'(cnt_o), 0);

        cur_req = "R2";
        wp_en = 1'b1;
        wr(2'd0, BASE_ACT | SRC_XC0);
        chk("R2", "locked b_oe", 32'(wave_b_oe), 0);
        wp_en = 1'b0;
        wr(2'd0, BASE_ACT | SRC_XC0);
        chk("R2", "unlocked b_oe", 32'(wave_b_oe), 1);

        cur_req = "R13";
        wr(2'd3, 32'd6);
        cmd_en = 1'b1; sw_trig = 1'b1; step();
        run(20);
        cmd_dis = 1'b1; step();
        held = cnt_o;
        run(12);
        chk("R13", "held while off", 32'(cnt_o), 32'(held));
        cmd_en = 1'b1; cmd_dis = 1'b1; step();
        run(6);
        chk("R13", "disable wins", 32'(cnt_o), 32'(held));
        cmd_en = 1'b1; step();
        run(10);

        cur_req = "R5";
        wr(2'd3, 32'd9);
        wr(2'd1, 32'd4);
        wr(2'd2, 32'd7);
        for (int ws = 0; ws < 4; ws++) begin
            wr(2'd0, BASE_ACT | SRC_XC0 | (32'(ws) << 22));
            sw_trig = 1'b1; step();
            run(80);
        end
        wr(2'd0, BASE_ACT | SRC_XC0);
        sw_trig = 1'b1; step();
        run(2 * 1024 + 40);
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd1 << 22));
        sw_trig = 1'b1; step();
        run(2 * 1024 + 60);

        cur_req = "R7";
        wr(2'd3, 32'd5);
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd1 << 29));
        sw_trig = 1'b1; step();
        run(40);
        chk("R7", "stopped at C", 32'(cnt_o), 5);
        sw_trig = 1'b1; step();
        run(4);
        chk("R7", "restart after stop", 32'(cnt_o != 0), 1);
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd1 << 30));
        sw_trig = 1'b1; step();
        run(40);
        chk("R7", "clock off at C", 32'(cnt_o), 5);
        sw_trig = 1'b1; step();
        run(10);
        chk("R7", "trigger alone", 32'(cnt_o), 0);
        cmd_en = 1'b1; step();
        run(4);
        chk("R7", "enable resumes", 32'(cnt_o != 0), 1);

        cur_req = "R11";
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd1 << 24));
        xc = 3'b000; step();
        xc[0] = 1'b1; step();
        chk("R11", "ext clears", 32'(wave_a), 0);
        xc[0] = 1'b0; step();
        xc[0] = 1'b1; sw_trig = 1'b1; step();
        chk("R11", "sw over ext", 32'(wave_a), 1);
        xc[0] = 1'b0; step();
        xc[0] = 1'b1; step();
        chk("R11", "ext alone", 32'(wave_a), 0);

        cur_req = "R3";
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd6 << 16) | (32'd1 << 19));
        cmd_en = 1'b1; sw_trig = 1'b1; step();
        knobs(0, 40, 0, 0);
        run(300);
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd3 << 16) | (32'd2 << 22));
        run(300);

        cur_req = "R4";
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd2 << 20));
        knobs(1, 25, 0, 0);
        run(400);

        cur_req = "R8";
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd1 << 24) | (32'd1 << 28));
        knobs(0, 6, 0, 0);
        run(400);

        cur_req = "R9";
        for (int e = 1; e < 4; e++) begin
            wr(2'd0, BASE_ACT | (32'(e) << 26) | (32'(e) << 24) | (32'd3 << 22));
            run(250);
        end

        cur_req = "R12";
        wr(2'd0, BASE_ACT | (32'd3 << 24) | (32'd2 << 22));
        knobs(3, 10, 20, 0);
        run(400);
        chk("R12", "line B released", 32'(wave_b_oe), 0);

        cur_req = "R6";
        wr(2'd1, 32'd3); wr(2'd2, 32'd11); wr(2'd3, 32'd14);
        wr(2'd0, BASE_ACT | SRC_XC0 | (32'd2 << 22));
        knobs(0, 0, 0, 0);
        cmd_en = 1'b1; sw_trig = 1'b1; step();
        run(300);

        cur_req = "R10";
        for (int blk = 0; blk < 12; blk++) begin
            wr(2'd1, 32'($urandom_range(20)));
            wr(2'd2, 32'($urandom_range(20)));
            wr(2'd3, 32'($urandom_range(24, 4)));
            wr(2'd0, $urandom & 32'h7FFF_FFFF);
            knobs($urandom_range(3), $urandom_range(30), $urandom_range(30), $urandom_range(4));
            cmd_en = 1'b1; sw_trig = 1'b1; step();
            run(300);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule